// File: doc/BRIEF.md
# DRAM Page-Mode Access Controller

This block turns single-word requests from a synchronous requester into the strobe sequences of an asynchronous-style DRAM device. The device has active-low row strobe, column strobe, chip enable and write enable, and one shared address bus. The requester offers an address, a direction and write data. The controller splits the address into a row part and a column part. It opens the row and then strobes the column, and it reports completion with a single-cycle pulse. Read data is valid in that same cycle.

After an access the row is left open. A later request to the same row strobes only the column. A request to another row first closes the page and waits out the precharge time. A free-running timer raises a refresh need at a fixed interval. At the next idle point the controller closes any open page and runs a refresh in which the column strobe falls before the row strobe. While the refresh waits or runs, no request is accepted. All strobe phase lengths are parameters counted in clock cycles.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the row strobe, column strobe, chip enable and write enable are all high (inactive), `done` is low and `req_ready` is high.
- R2: The request address is split with the row in the upper ROW_W bits and the column in the lower COL_W bits. The row is on `dram_addr` when the row strobe falls, and the column is on it while the column strobe is low.
- R3: Every accepted request produces exactly one `done` pulse, one cycle wide. For a read, `rd_data` in that cycle holds the word most recently written to that address.
- R4: Back-to-back requests to the row that is already open keep the row strobe low. They produce no new row activation, only new column strobes.
- R5: Before each fall of the row strobe, it has been high for at least T_RP cycles (a reset counts as a completed precharge).
- R6: Each column strobe in an access falls at least T_RCD cycles after the row strobe fell, and every column-strobe low period lasts at least T_CAS cycles.
- R7: A refresh starts with the column strobe falling while the row strobe is high, and it moves no data. Refreshes recur every REF_INTERVAL cycles while the controller is idle. Two refresh starts are never more than REF_INTERVAL + 2*T_RP + T_RCD + 2*T_CAS + 4 cycles apart.
- R8: `req_ready` is low while a refresh is pending or in progress.
- R9: Chip enable is low whenever either strobe is low. Write enable is low only during the column phase of a write, while `dram_dq_oe` drives the write data.
- R10: After a request is accepted, `req_ready` stays low until the cycle of its `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address: row in the upper bits, column in the lower bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request is taken when both valid and ready are high at a clock edge |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Read data, valid when done is high after a read |
| dram_ce_n | output | 1 | Chip enable, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low (high = read) |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Data toward the device |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | DATA_W | Data from the device |

## Verification
The assertions check the timing rules on every cycle: precharge length, row-to-column delay and column pulse width, column-first ordering and the deadline between refreshes, refusal of requests around refresh, strobe and enable coverage, and the one-cycle done pulse with the hold-off after acceptance. Data integrity depends on the split of the address into row and column, which only the bench can show. It does so with a behavioural memory and a scoreboard of expected read words. The bench scenarios also show that a same-row burst reuses the open row, that a row change costs one activation per switch, and that idle refreshes occur at the programmed rate.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting; page may be open
    ST_PRE,    // row strobe high, precharging
    ST_ROW,    // row strobe low, row address on bus
    ST_COL,    // column strobe low, data transfer
    ST_RCAS,   // refresh: column strobe low first
    ST_RRAS,   // refresh: row strobe joins
    ST_RPRE    // refresh: both high, precharge
  } dpc_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dpc_phase_timer.sv
module dpc_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dpc_refresh_timer.sv
module dpc_refresh_timer #(
  parameter int INTERVAL = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic served,
  output logic pending
);
  localparam int CW = $clog2(INTERVAL + 1);
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= RELOAD;
      pending <= 1'b0;
    end else begin
      cnt <= tick ? RELOAD : cnt - 1'b1;
      if (tick)        pending <= 1'b1;
      else if (served) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/dpc_open_row.sv
module dpc_open_row #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_en,
  input  logic             close_en,
  input  logic [ROW_W-1:0] row_in,
  input  logic [ROW_W-1:0] probe_row,
  output logic             is_open,
  output logic             hit
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      row_q   <= '0;
    end else if (close_en) begin
      is_open <= 1'b0;
    end else if (open_en) begin
      is_open <= 1'b1;
      row_q   <= row_in;
    end
  end

  assign hit = is_open && (row_q == probe_row);
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dpc_pkg::*;
#(
  parameter int ROW_W        = 8,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 16,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 3,
  parameter int REF_INTERVAL = 1000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [ROW_W+COL_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      req_ready,
  output logic                      done,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      dram_ce_n,
  output logic                      dram_ras_n,
  output logic                      dram_cas_n,
  output logic                      dram_we_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]         dram_dq_out,
  output logic                      dram_dq_oe,
  input  logic [DATA_W-1:0]         dram_dq_in
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int PH_W   = $clog2(max3(T_RCD, T_CAS, T_RP) + 1);

  function automatic logic [ROW_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: ROW_W];
  endfunction

  function automatic logic [COL_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[COL_W-1:0];
  endfunction

  function automatic logic [PH_W-1:0] phase_load(input dpc_state_e s);
    int n;
    case (s)
      ST_PRE, ST_RPRE:         n = T_RP;
      ST_ROW:                  n = T_RCD;
      ST_COL, ST_RCAS, ST_RRAS: n = T_CAS;
      default:                 n = 1;
    endcase
    return PH_W'(n - 1);
  endfunction

  dpc_state_e        st, st_nxt;
  logic              ph_expired;
  logic              ref_pending;
  logic              row_open, row_hit;
  logic              job_ref;
  logic [ADDR_W-1:0] lat_addr;
  logic              lat_wr;
  logic [DATA_W-1:0] lat_wdata;

  // named internal events
  logic accept;      // request taken this cycle
  logic ref_served;  // refresh sequence begins next cycle
  logic col_done;    // last cycle of a column transfer
  logic ph_load;

  assign req_ready  = (st == ST_IDLE) && !ref_pending;
  assign accept     = req_valid && req_ready;
  assign col_done   = (st == ST_COL) && ph_expired;
  assign ph_load    = (st_nxt != st);
  assign ref_served = (st_nxt == ST_RCAS) && (st != ST_RCAS);

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE: begin
        if (ref_pending)  st_nxt = row_open ? ST_PRE : ST_RCAS;
        else if (accept)  st_nxt = row_hit ? ST_COL : (row_open ? ST_PRE : ST_ROW);
      end
      ST_PRE:  if (ph_expired) st_nxt = job_ref ? ST_RCAS : ST_ROW;
      ST_ROW:  if (ph_expired) st_nxt = ST_COL;
      ST_COL:  if (ph_expired) st_nxt = ST_IDLE;
      ST_RCAS: if (ph_expired) st_nxt = ST_RRAS;
      ST_RRAS: if (ph_expired) st_nxt = ST_RPRE;
      ST_RPRE: if (ph_expired) st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  dpc_phase_timer #(.CNT_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load),
    .load_val(phase_load(st_nxt)), .expired(ph_expired)
  );

  dpc_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_refresh (
    .clk(clk), .rst_n(rst_n), .served(ref_served), .pending(ref_pending)
  );

  dpc_open_row #(.ROW_W(ROW_W)) u_page (
    .clk(clk), .rst_n(rst_n),
    .open_en(st == ST_ROW),
    .close_en((st == ST_PRE) || (st == ST_RCAS)),
    .row_in(row_of(lat_addr)), .probe_row(row_of(req_addr)),
    .is_open(row_open), .hit(row_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      job_ref   <= 1'b0;
      lat_addr  <= '0;
      lat_wr    <= 1'b0;
      lat_wdata <= '0;
      done      <= 1'b0;
      rd_data   <= '0;
    end else begin
      st   <= st_nxt;
      done <= col_done;
      if (st == ST_IDLE && ref_pending) job_ref <= 1'b1;
      else if (accept)                  job_ref <= 1'b0;
      if (accept) begin
        lat_addr  <= req_addr;
        lat_wr    <= req_write;
        lat_wdata <= req_wdata;
      end
      if (col_done && !lat_wr) rd_data <= dram_dq_in;
    end
  end

  logic ras_low, cas_low;
  assign ras_low = (st == ST_ROW) || (st == ST_COL) || (st == ST_RRAS) ||
                   ((st == ST_IDLE) && row_open);
  assign cas_low = (st == ST_COL) || (st == ST_RCAS) || (st == ST_RRAS);

  assign dram_ras_n  = !ras_low;
  assign dram_cas_n  = !cas_low;
  assign dram_ce_n   = !(ras_low || cas_low);
  assign dram_we_n   = !((st == ST_COL) && lat_wr);
  assign dram_dq_oe  = (st == ST_COL) && lat_wr;
  assign dram_dq_out = lat_wdata;

  always_comb begin
    dram_addr = '0;
    if (st == ST_ROW)      dram_addr = MA_W'(row_of(lat_addr));
    else if (st == ST_COL) dram_addr = MA_W'(col_of(lat_addr));
  end
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 3,
  parameter int REF_INTERVAL = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic ce_n,
  input logic we_n,
  input logic dq_oe,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic ref_pending
);
  localparam int REF_LIMIT = REF_INTERVAL + 2*T_RP + T_RCD + 2*T_CAS + 4;

  logic [15:0] ras_hi_cnt, ras_lo_cnt, cas_lo_cnt;
  int          since_ref;
  logic        cas_q;
  logic        cbr_start;

  assign cbr_start = !cas_n && cas_q && ras_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_hi_cnt <= 16'(T_RP);
      ras_lo_cnt <= '0;
      cas_lo_cnt <= '0;
      since_ref  <= 0;
      cas_q      <= 1'b1;
    end else begin
      ras_hi_cnt <= !ras_n ? 16'd0 : ((ras_hi_cnt == 16'hFFFF) ? ras_hi_cnt : ras_hi_cnt + 1'b1);
      ras_lo_cnt <= ras_n  ? 16'd0 : ((ras_lo_cnt == 16'hFFFF) ? ras_lo_cnt : ras_lo_cnt + 1'b1);
      cas_lo_cnt <= cas_n  ? 16'd0 : ((cas_lo_cnt == 16'hFFFF) ? cas_lo_cnt : cas_lo_cnt + 1'b1);
      since_ref  <= cbr_start ? 0 : since_ref + 1;
      cas_q      <= cas_n;
    end
  end

  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> ras_hi_cnt >= 16'(T_RP));                       // R5
  AST_RAS_TO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !ras_n) |-> ras_lo_cnt >= 16'(T_RCD));          // R6
  AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> cas_lo_cnt >= 16'(T_CAS));                      // R6
  AST_CBR_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> (we_n && !dq_oe));                          // R7
  AST_REFRESH_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    since_ref <= REF_LIMIT);                                          // R7
  AST_READY_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ref_pending);                                      // R8
  AST_NO_READY_IN_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && ras_n) |-> !req_ready);                                // R8
  AST_CE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n) |-> !ce_n);                                    // R9
  AST_WE_IN_COL: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cas_n && !ras_n && dq_oe));                           // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                  // R3
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);                         // R10
endmodule

bind dram_page_ctrl dpc_checker #(
  .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .REF_INTERVAL(REF_INTERVAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .ce_n(dram_ce_n), .we_n(dram_we_n), .dq_oe(dram_dq_oe),
  .req_valid(req_valid), .req_ready(req_ready), .done(done),
  .ref_pending(ref_pending)
);

// File: tb/dram_page_ctrl_tb.sv
`timescale 1ns/1ps
module dram_page_ctrl_tb;
  localparam int ROW_W = 4, COL_W = 4, DATA_W = 16;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 3, REF_I = 150;
  localparam int AW = ROW_W + COL_W;
  localparam int MA = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, done;
  logic [DATA_W-1:0] rd_data, dq_out, dq_in;
  logic ce_n, ras_n, cas_n, we_n, dq_oe;
  logic [MA-1:0] maddr;

  always #2.5 clk = ~clk;

  dram_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
                   .T_CAS(T_CAS), .T_RP(T_RP), .REF_INTERVAL(REF_I)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .done(done), .rd_data(rd_data), .dram_ce_n(ce_n), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_addr(maddr),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural memory, sampled mid-cycle
  logic [DATA_W-1:0] mem [1<<AW];
  logic [DATA_W-1:0] shadow [1<<AW];
  logic [ROW_W-1:0] row_lat = '0;
  logic pras = 1, pcas = 1, pdone = 0, in_ref = 0, busy = 0;
  int act_cnt = 0, ref_cnt = 0, cbr_cnt = 0;
  int ras_hi = T_RP, ras_lo = 0, cas_lo = 0;
  int v_rp = 0, v_rcd = 0, v_cas = 0, v_ref = 0, v_ce = 0, v_we = 0, v_done = 0, v_hold = 0;

  assign dq_in = mem[{row_lat, maddr[COL_W-1:0]}];

  always @(negedge clk) if (rst_n) begin
    if (!ras_n && pras) begin
      if (!cas_n) ref_cnt++;
      else begin row_lat = maddr[ROW_W-1:0]; act_cnt++; end
      if (ras_hi < T_RP) v_rp++;                                  // R5
    end
    if (!cas_n && pcas) begin
      if (ras_n) begin cbr_cnt++; in_ref = 1; end
      else begin
        if (ras_lo < T_RCD) v_rcd++;                              // R6
        if (!we_n) mem[{row_lat, maddr[COL_W-1:0]}] = dq_out;     // R2
      end
    end
    if (cas_n && !pcas && cas_lo < T_CAS) v_cas++;                // R6
    if (cas_n) in_ref = 0;
    if (in_ref && (req_ready || !we_n || dq_oe)) v_ref++;          // R8
    if ((!ras_n || !cas_n) && ce_n) v_ce++;                        // R9
    if (!we_n && !(dq_oe && !cas_n)) v_we++;                       // R9
    if (done && pdone) v_done++;                                   // R3
    if (done) busy = 0;
    if (busy && req_ready) v_hold++;                               // R10
    ras_hi = ras_n ? ras_hi + 1 : 0;
    ras_lo = ras_n ? 0 : ras_lo + 1;
    cas_lo = cas_n ? 0 : cas_lo + 1;
    pras = ras_n; pcas = cas_n; pdone = done;
  end

  always @(posedge clk) if (rst_n && req_valid && req_ready) busy <= 1;

  // scoreboard
  typedef struct { bit wr; logic [AW-1:0] a; logic [DATA_W-1:0] d; } item_t;
  item_t q[$];

  always @(negedge clk) if (rst_n && done) begin
    if (q.size() == 0) chk(0, "R3 unexpected done", 1, 0);
    else begin
      item_t it;
      it = q.pop_front();
      if (it.wr) chk(1, "R3 write done", 1, 1);
      else chk(rd_data === it.d, "R3/R2 read data", rd_data, it.d);
    end
  end

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
    item_t it;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    if (wr) shadow[a] = d;
    it.wr = wr; it.a = a; it.d = shadow[a];
    q.push_back(it);
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic wait_refresh();
    int c0;
    c0 = cbr_cnt;
    while (cbr_cnt == c0) @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  bit finished = 0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int a0;
    for (int i = 0; i < (1 << AW); i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && ce_n && we_n && !done, "R1 strobes in reset",
        {ras_n, cas_n, ce_n, we_n, done}, 5'b11110);
    rst_n = 1;
    @(negedge clk);
    chk(ras_n && cas_n && ce_n && we_n && !done && req_ready, "R1 after reset",
        {ras_n, cas_n, ce_n, we_n, done, req_ready}, 6'b111101);

    // R2 R3: scattered writes then reads
    for (int i = 0; i < 8; i++) do_req(1, AW'(i * 37 + 5), DATA_W'(16'hA000 + i * 3));
    for (int i = 7; i >= 0; i--) do_req(0, AW'(i * 37 + 5), '0);

    // R4: same-row burst opens the row once
    wait_refresh();
    a0 = act_cnt;
    for (int c = 0; c < 4; c++) do_req(1, {4'd5, 4'(c)}, DATA_W'(16'h5500 + c));
    do_req(0, {4'd5, 4'd2}, '0);
    do_req(0, {4'd5, 4'd0}, '0);
    chk(act_cnt - a0 == 1, "R4 row activations in page burst", act_cnt - a0, 1);

    // R5: alternating rows reopen each time
    wait_refresh();
    a0 = act_cnt;
    do_req(0, {4'd1, 4'd3}, '0);
    do_req(1, {4'd2, 4'd3}, 16'h2323);
    do_req(0, {4'd1, 4'd3}, '0);
    chk(act_cnt - a0 == 3, "R5 row activations on row changes", act_cnt - a0, 3);

    // R7: idle refresh rate and column-first order
    wait_refresh();
    a0 = cbr_cnt;
    repeat (3 * REF_I + 2) @(negedge clk);
    chk(cbr_cnt - a0 == 3, "R7 idle refresh count", cbr_cnt - a0, 3);
    chk(ref_cnt == cbr_cnt, "R7 row strobe joins column-first refresh", ref_cnt, cbr_cnt);

    // R8 R3: dense traffic across many refreshes
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = AW'((i * 29 + i / 7) % (1 << AW));
      if (i % 5 == 0) a = {a[AW-1 -: ROW_W] ^ 4'd9, a[COL_W-1:0]};
      do_req((i % 3) != 1, a, DATA_W'(i * 613 + 11));
    end
    a0 = ref_cnt;
    chk(a0 >= 10, "R7 refreshes during traffic", a0, 10);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R3 all requests completed", q.size(), 0);
    chk(v_rp == 0, "R5 precharge violations", v_rp, 0);
    chk(v_rcd == 0, "R6 row-to-column violations", v_rcd, 0);
    chk(v_cas == 0, "R6 column width violations", v_cas, 0);
    chk(v_ref == 0, "R8 activity during refresh", v_ref, 0);
    chk(v_ce == 0, "R9 chip enable coverage", v_ce, 0);
    chk(v_we == 0, "R9 write enable outside write column", v_we, 0);
    chk(v_done == 0, "R3 done wider than one cycle", v_done, 0);
    chk(v_hold == 0, "R10 ready while busy", v_hold, 0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule